// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines from peripherals and drives a single prioritized request, plus a three-bit level code, toward a host processor. The host programs it over a simple 32-bit register port that has read and write strobes, a word address and byte-lane enables. It enables individual sources in a mask register and turns the request output on with a global enable bit in the configuration register. When the request is raised, the host writes the acknowledge bit of the vector register. This latches the winning source number and marks that source as in service. A read of the vector register then returns the number in bits 15:11.

Priority is fixed: the highest vector number wins. A source that is in service is excluded from arbitration. While service is open, the request is held back unless a source of strictly higher number is waiting. The host ends service by writing a one to the source's bit in the in-service register. A source that still holds its line high then pends again. Vector 0 is never a real source; it is reported when an acknowledge finds no qualifying request, for example because the source was masked between raising the request and the acknowledge. Four channel positions (vectors 4 to 7) can be reassigned among four serial channel inputs through slot fields in the configuration register.

Top module: `vic_ctrl`

## Requirements
- R1: A source n can win only while bit n of the mask register (word 3) is one; clearing the bit withdraws its request on the output within one cycle of the write taking effect.
- R2: After reset the mask, pending, in-service and vector registers read zero, the global enable (configuration bit 0) and level field are zero, the slot fields hold their identity values (configuration word 0x001B0000), and irq_o is low.
- R3: irq_o is driven only while configuration bit 0 is one; it follows the qualified request with one register stage.
- R4: Among sources that are pending, unmasked and not in service, the highest vector number is chosen; input line 0 is shown in the pending register (word 2) but never requests.
- R5: A write to word 1 with byte lane 0 enabled and data bit 0 set latches the chosen vector and sets its in-service bit; a read of word 1 returns the vector in bits 15:11 and zero elsewhere.
- R6: A write to the in-service register (word 4) clears each bit written as one and leaves the others unchanged.
- R7: While any vector is in service, irq_o rises only for a qualifying source whose number is strictly above the highest in-service vector.
- R8: An acknowledge with no qualifying request returns vector 0 and sets in-service bit 0, which the host clears like any other.
- R9: Inputs are level-sensitive: after its in-service bit is cleared, a source whose line is still high requests again.
- R10: Configuration bits 15:13 appear on irq_level_o.
- R11: Configuration slots A, B, C and D (bits 17:16, 19:18, 21:20, 23:22) each hold a channel number 0..3; vector 7-k takes the level of input line 4+slot[k] (A is k=0).
- R12: Reads of words 5 to 7 return zero and writes to them change no register.
- R13: A write changes only the bytes whose lane enable is set; data in disabled lanes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; read data is zero when low |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| src_i | input | 32 | Level-sensitive interrupt lines |
| irq_o | output | 1 | Prioritized interrupt request to the host |
| irq_level_o | output | 3 | Request level code |

## Verification
A corrupted mask, pending or in-service bit shows up at the ports within two clock edges: as a wrong irq_o value after the next input sample, or as a wrong vector when the host acknowledges. A stale latched vector or a missed in-service update is exposed on the next read of word 1 or word 4. A slot field that is decoded wrongly shows up only when a channel line is the sole active source, so the bench drives such a case on its own. The bench tracks every register in a behavioural model and compares irq_o, irq_level_o and the read data on each cycle. Any deviation is therefore caught in the cycle where it first becomes visible.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
    localparam int NSRC    = 32;
    localparam int VEC_W   = $clog2(NSRC);
    localparam int DW      = 32;
    localparam int AW      = 3;
    localparam int NCH     = 4;
    localparam int SLW     = $clog2(NCH);
    localparam int CH_BASE = 4;
    localparam int LVL_W   = 3;
    localparam int LVL_LSB = 13;
    localparam int SLOT_LSB = 16;
    localparam int VEC_LSB = 11;

    localparam logic [AW-1:0] OFF_CFG  = 3'd0;
    localparam logic [AW-1:0] OFF_VEC  = 3'd1;
    localparam logic [AW-1:0] OFF_PEND = 3'd2;
    localparam logic [AW-1:0] OFF_MASK = 3'd3;
    localparam logic [AW-1:0] OFF_INSV = 3'd4;

    typedef struct packed {
        logic [NCH-1:0][SLW-1:0] slot;
        logic [LVL_W-1:0]        level;
        logic                    en;
    } cfg_t;

    function automatic logic [DW-1:0] lane_mask(input logic [DW/8-1:0] be);
        logic [DW-1:0] m;
        for (int b = 0; b < DW/8; b++) m[8*b +: 8] = {8{be[b]}};
        return m;
    endfunction

    function automatic logic [DW-1:0] cfg_to_word(input cfg_t c);
        logic [DW-1:0] w;
        w = '0;
        w[0] = c.en;
        w[LVL_LSB +: LVL_W] = c.level;
        for (int k = 0; k < NCH; k++) w[SLOT_LSB + SLW*k +: SLW] = c.slot[k];
        return w;
    endfunction

    function automatic cfg_t word_to_cfg(input logic [DW-1:0] w);
        cfg_t c;
        c.en = w[0];
        c.level = w[LVL_LSB +: LVL_W];
        for (int k = 0; k < NCH; k++) c.slot[k] = w[SLOT_LSB + SLW*k +: SLW];
        return c;
    endfunction

    function automatic cfg_t cfg_reset();
        cfg_t c;
        c.en = 1'b0;
        c.level = '0;
        for (int k = 0; k < NCH; k++) c.slot[k] = SLW'(NCH - 1 - k);
        return c;
    endfunction
endpackage

// File: rtl/vic_remap.sv
`timescale 1ns/1ps
module vic_remap #(
    parameter int N    = 32,
    parameter int NC   = 4,
    parameter int BASE = 4,
    parameter int SW   = $clog2(NC)
) (
    input  logic [N-1:0]          lines_i,
    input  logic [NC-1:0][SW-1:0] slot_i,
    output logic [N-1:0]          lines_o
);
    localparam int TOP = BASE + NC - 1;

    for (genvar v = 0; v < N; v++) begin : g_bit
        if (v >= BASE && v <= TOP) begin : g_chan
            localparam int K = TOP - v;
            logic [NC-1:0] grp;
            assign grp = lines_i[BASE +: NC];
            assign lines_o[v] = grp[slot_i[K]];
        end else begin : g_pass
            assign lines_o[v] = lines_i[v];
        end
    end
endmodule

// File: rtl/vic_prio.sv
`timescale 1ns/1ps
module vic_prio #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] top_o
);
    always_comb begin
        top_o = '0;
        for (int i = 0; i < W; i++) begin
            if (vec_i[i]) top_o = IW'(i);
        end
    end
    assign any_o = |vec_i;
endmodule

// File: rtl/vic_ctrl.sv
`timescale 1ns/1ps
module vic_ctrl
    import vic_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic [3:0]    bus_be,
    output logic [DW-1:0] bus_rdata,
    input  logic [NSRC-1:0] src_i,
    output logic          irq_o,
    output logic [LVL_W-1:0] irq_level_o
);
    localparam logic [NSRC-1:0] REAL_SRC = ~NSRC'(1);

    cfg_t             cfg_q;
    logic [NSRC-1:0]  mask_q, pend_q, insv_q;
    logic [VEC_W-1:0] vec_q;
    logic             irq_q;

    logic [DW-1:0]    bm;
    logic             wr_cfg, wr_mask, wr_insv, ack;
    logic [NSRC-1:0]  remapped, cand;
    logic             cand_any, insv_any, req_raw;
    logic [VEC_W-1:0] cand_top, insv_top, ack_vec;

    assign bm      = lane_mask(bus_be);
    assign wr_cfg  = bus_wr && (bus_addr == OFF_CFG);
    assign wr_mask = bus_wr && (bus_addr == OFF_MASK);
    assign wr_insv = bus_wr && (bus_addr == OFF_INSV);
    assign ack     = bus_wr && (bus_addr == OFF_VEC) && bus_be[0] && bus_wdata[0];

    vic_remap #(.N(NSRC), .NC(NCH), .BASE(CH_BASE), .SW(SLW)) u_remap (
        .lines_i(src_i),
        .slot_i (cfg_q.slot),
        .lines_o(remapped)
    );

    assign cand = pend_q & mask_q & ~insv_q & REAL_SRC;

    vic_prio #(.W(NSRC), .IW(VEC_W)) u_prio_cand (
        .vec_i(cand), .any_o(cand_any), .top_o(cand_top)
    );
    vic_prio #(.W(NSRC), .IW(VEC_W)) u_prio_insv (
        .vec_i(insv_q), .any_o(insv_any), .top_o(insv_top)
    );

    assign req_raw = cand_any && (!insv_any || (cand_top > insv_top));
    assign ack_vec = req_raw ? cand_top : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= cfg_reset();
            mask_q <= '0;
            pend_q <= '0;
            insv_q <= '0;
            vec_q  <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= remapped;
            irq_q  <= cfg_q.en && req_raw;
            if (wr_cfg)
                cfg_q <= word_to_cfg((cfg_to_word(cfg_q) & ~bm) | (bus_wdata & bm));
            if (wr_mask)
                mask_q <= (mask_q & ~bm) | (bus_wdata & bm);
            if (wr_insv)
                insv_q <= insv_q & ~(bus_wdata & bm);
            else if (ack)
                insv_q <= insv_q | (NSRC'(1) << ack_vec);
            if (ack)
                vec_q <= ack_vec;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFF_CFG:  bus_rdata = cfg_to_word(cfg_q);
                OFF_VEC:  bus_rdata = {{(DW-VEC_LSB-VEC_W){1'b0}}, vec_q, {VEC_LSB{1'b0}}};
                OFF_PEND: bus_rdata = pend_q;
                OFF_MASK: bus_rdata = mask_q;
                OFF_INSV: bus_rdata = insv_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq_o       = irq_q;
    assign irq_level_o = cfg_q.level;
endmodule

// File: rtl/vic_ctrl_chk.sv
`timescale 1ns/1ps
module vic_ctrl_chk
    import vic_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [DW-1:0]    bus_wdata,
    input logic [3:0]       bus_be,
    input logic             irq_o,
    input logic             cfg_en,
    input logic             req_raw,
    input logic [NSRC-1:0]  mask_q,
    input logic [NSRC-1:0]  insv_q,
    input logic [VEC_W-1:0] vec_q
);
    logic ack_seen;
    assign ack_seen = bus_wr && (bus_addr == OFF_VEC) && bus_be[0] && bus_wdata[0];

    // R3: output stays low in the cycle after the global enable is off
    assert_gate_R3: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> !irq_o);

    // R6: bits written as one are clear after the write
    assert_w1c_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_INSV) |=>
        ((insv_q & $past(bus_wdata & lane_mask(bus_be))) == '0));

    // R5: the latched vector is marked in service
    assert_ack_insv_R5: assert property (@(posedge clk) disable iff (rst)
        ack_seen |=> insv_q[vec_q]);

    // R1: a real vector returned by an acknowledge was unmasked at that time
    assert_unmasked_R1: assert property (@(posedge clk) disable iff (rst)
        ack_seen |=> ((vec_q == '0) || ((($past(mask_q) >> vec_q) & NSRC'(1)) != '0)));

    // R8: acknowledge without a qualifying request yields the error vector
    assert_errvec_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_seen && !req_raw) |=> (vec_q == '0 && insv_q[0]));
endmodule

bind vic_ctrl vic_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_be   (bus_be),
    .irq_o    (irq_o),
    .cfg_en   (cfg_q.en),
    .req_raw  (req_raw),
    .mask_q   (mask_q),
    .insv_q   (insv_q),
    .vec_q    (vec_q)
);

// File: tb/sim_vic_ctrl.sv
`timescale 1ns/1ps
module sim_vic_ctrl;
    localparam int A_CFG = 0, A_VEC = 1, A_PEND = 2, A_MASK = 3, A_INSV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src = '0;
    logic        irq_o;
    logic [2:0]  irq_level_o;

    int n_cmp = 0, n_bad = 0;
    bit started = 0, done = 0;
    string cur_tag = "R2";

    always #5 clk = ~clk;

    vic_ctrl u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .src_i(src), .irq_o(irq_o),
        .irq_level_o(irq_level_o)
    );

    // behavioural model state
    bit          m_en, m_irq;
    logic [2:0]  m_lvl;
    int          m_slot [4];
    logic [31:0] m_mask, m_pend, m_insv;
    int          m_vec;

    function automatic int top_of(logic [31:0] v);
        for (int i = 31; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    function automatic logic [31:0] m_cfg_word();
        logic [31:0] w = '0;
        w[0] = m_en;
        w[15:13] = m_lvl;
        for (int k = 0; k < 4; k++) w[16 + 2*k +: 2] = 2'(m_slot[k]);
        return w;
    endfunction

    function automatic logic [31:0] m_read(logic [2:0] a);
        case (a)
            3'd0: return m_cfg_word();
            3'd1: return 32'(m_vec) << 11;
            3'd2: return m_pend;
            3'd3: return m_mask;
            3'd4: return m_insv;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_en = 0; m_lvl = '0; m_mask = '0; m_pend = '0; m_insv = '0;
            m_vec = 0; m_irq = 0;
            for (int k = 0; k < 4; k++) m_slot[k] = 3 - k;
        end else begin
            logic [31:0] cand, bm, npend, w;
            int tc, ti;
            bit ok, nirq;
            cand = m_pend & m_mask & ~m_insv & ~32'd1;
            tc = top_of(cand);
            ti = top_of(m_insv);
            ok = (tc > 0) && (tc > ti);
            nirq = m_en && ok;
            for (int v = 0; v < 32; v++) begin
                if (v >= 4 && v <= 7) npend[v] = src[4 + m_slot[7 - v]];
                else npend[v] = src[v];
            end
            for (int b = 0; b < 4; b++) bm[8*b +: 8] = {8{bus_be[b]}};
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: begin
                        w = (m_cfg_word() & ~bm) | (bus_wdata & bm);
                        m_en = w[0]; m_lvl = w[15:13];
                        for (int k = 0; k < 4; k++) m_slot[k] = int'(w[16 + 2*k +: 2]);
                    end
                    3'd1: if (bus_be[0] && bus_wdata[0]) begin
                        m_vec = ok ? tc : 0;
                        m_insv[m_vec] = 1'b1;
                    end
                    3'd3: m_mask = (m_mask & ~bm) | (bus_wdata & bm);
                    3'd4: m_insv = m_insv & ~(bus_wdata & bm);
                    default: ;
                endcase
            end
            m_pend = npend;
            m_irq = nirq;
        end
    end

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the clock edge
    always @(negedge clk) begin
        if (started && !done) begin
            check(cur_tag, "irq_o", 32'(irq_o), 32'(m_irq));
            check(cur_tag, "irq_level_o", 32'(irq_level_o), 32'(m_lvl));
            check(cur_tag, "bus_rdata", bus_rdata, bus_rd ? m_read(bus_addr) : 32'd0);
        end
    end

    task automatic wr(int a, logic [31:0] d, logic [3:0] be);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = 3'(a); bus_wdata = d; bus_be = be;
        @(posedge clk); #1;
        bus_wr = 0; bus_be = '0;
    endtask

    task automatic rd_expect(int a, logic [31:0] exp, string tag);
        @(posedge clk); #1;
        bus_rd = 1; bus_addr = 3'(a);
        @(negedge clk);
        check(tag, "read", bus_rdata, exp);
        @(posedge clk); #1;
        bus_rd = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic irq_expect(logic exp, string tag);
        @(negedge clk);
        check(tag, "irq explicit", 32'(irq_o), 32'(exp));
    endtask

    task automatic set_src(logic [31:0] v);
        @(posedge clk); #1;
        src = v;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 0;
        // R2: reset state
        cur_tag = "R2";
        rd_expect(A_CFG, 32'h001B0000, "R2");
        rd_expect(A_MASK, 32'h0, "R2");
        rd_expect(A_INSV, 32'h0, "R2");
        irq_expect(1'b0, "R2");

        // R12: unimplemented words
        cur_tag = "R12";
        rd_expect(5, 32'h0, "R12");
        wr(6, 32'hFFFFFFFF, 4'hF);
        rd_expect(7, 32'h0, "R12");
        rd_expect(A_CFG, 32'h001B0000, "R12");

        // R3: global enable gates the request
        cur_tag = "R3";
        set_src(32'h1 << 9);
        wr(A_MASK, 32'hFFFFFFFF, 4'hF);
        idle(3);
        irq_expect(1'b0, "R3");
        wr(A_CFG, 32'h001B0001, 4'hF);
        idle(2);
        irq_expect(1'b1, "R3");

        // R1: masking withdraws the request
        cur_tag = "R1";
        wr(A_MASK, ~(32'h1 << 9), 4'hF);
        idle(2);
        irq_expect(1'b0, "R1");
        wr(A_MASK, 32'hFFFFFFFF, 4'hF);

        // R10 and R13: level field written through byte lane 1 only
        cur_tag = "R10";
        wr(A_CFG, 32'hFFFFA0FF, 4'b0010);
        idle(1);
        check("R10", "level", 32'(irq_level_o), 32'd5);
        rd_expect(A_CFG, 32'h001BA001, "R13");

        // R4: highest of several, line 0 never requests
        cur_tag = "R4";
        set_src((32'h1 << 3) | (32'h1 << 9) | (32'h1 << 20) | 32'h1);
        idle(3);
        rd_expect(A_PEND, (32'h1 << 3) | (32'h1 << 9) | (32'h1 << 20) | 32'h1, "R4");
        wr(A_VEC, 32'h1, 4'b0001);
        rd_expect(A_VEC, 32'd20 << 11, "R4");
        rd_expect(A_INSV, 32'h1 << 20, "R5");

        // R7: lower source held back, higher one passes
        cur_tag = "R7";
        idle(2);
        irq_expect(1'b0, "R7");
        set_src((32'h1 << 3) | (32'h1 << 9) | (32'h1 << 20) | (32'h1 << 25));
        idle(3);
        irq_expect(1'b1, "R7");
        cur_tag = "R5";
        wr(A_VEC, 32'h1, 4'b0001);
        rd_expect(A_VEC, 32'd25 << 11, "R5");

        // R6 and R13: write-one-to-clear with lane gating
        cur_tag = "R6";
        wr(A_INSV, 32'h1 << 25, 4'hF);
        rd_expect(A_INSV, 32'h1 << 20, "R6");
        wr(A_INSV, 32'h1 << 20, 4'b0001);
        rd_expect(A_INSV, 32'h1 << 20, "R13");

        // R9: still-asserted source requests again
        cur_tag = "R9";
        idle(2);
        irq_expect(1'b1, "R9");
        wr(A_VEC, 32'h1, 4'b0001);
        rd_expect(A_VEC, 32'd25 << 11, "R9");

        // R8: masked before acknowledge gives vector 0
        cur_tag = "R8";
        wr(A_INSV, 32'hFFFFFFFF, 4'hF);
        idle(2);
        wr(A_MASK, 32'h0, 4'hF);
        wr(A_VEC, 32'h1, 4'b0001);
        rd_expect(A_VEC, 32'h0, "R8");
        rd_expect(A_INSV, 32'h1, "R8");
        wr(A_INSV, 32'h1, 4'hF);
        rd_expect(A_INSV, 32'h0, "R8");

        // R11: channel 0 placed in slot A appears as vector 7
        cur_tag = "R11";
        set_src(32'h1 << 4);
        wr(A_MASK, 32'h1 << 7, 4'hF);
        wr(A_CFG, 32'h00D8A001, 4'hF);
        idle(3);
        irq_expect(1'b1, "R11");
        wr(A_VEC, 32'h1, 4'b0001);
        rd_expect(A_VEC, 32'd7 << 11, "R11");
        rd_expect(A_PEND, 32'h1 << 7, "R11");

        idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule